// File: doc/BRIEF.md
# Dual Signed Multiply-Subtract Accumulator

This datapath block takes two 32-bit operands, each carrying a pair of signed 16-bit halfwords, and a 32-bit signed addend. It multiplies the two bottom halfwords together and the two top halfwords together. It takes the top product away from the bottom product, adds the addend, and registers the low 32 bits of the exact sum. A swap control rotates the second operand by 16 bits before the multiply, so that each halfword of the first operand meets the opposite halfword of the second. A multiply-only control drops the addend.

A sticky saturation flag records any accumulation whose exact value does not fit in 32 signed bits. The block only ever sets the flag. It is cleared by the explicit clear input or by reset.

An operation is accepted when the valid input and the condition-pass input are both high. Every accepted operation has the same latency, one clock, whatever the operand values. A rejected cycle leaves the result, the flag and the valid output untouched.

Top module: `dual_mul_sub_acc`

## Requirements
- R1: For an accepted operation, `result` one clock later equals bits [31:0] of (opA[15:0]·B[15:0] − opA[31:16]·B[31:16] + addend), with every field taken as signed two's complement.
- R2: The subtraction takes the top-halfword product away from the bottom-halfword product, never the other way round.
- R3: With `swapHalves` high, B is opB rotated by 16 bits ({opB[15:0], opB[31:16]}), so the products become opA[15:0]·opB[31:16] and opA[31:16]·opB[15:0].
- R4: With `mulOnly` high, the addend is treated as zero, and `result` is the low 32 bits of the product difference.
- R5: In accumulate mode (`mulOnly` low), `satFlag` goes to 1 one clock after an accepted operation whose exact sum lies outside [−2^31, 2^31−1]. This includes the extreme case where every halfword is −32768 or 32767 and the addend is 0x7FFFFFFF or 0x80000000.
- R6: An accepted operation with `mulOnly` high never sets `satFlag`.
- R7: Once set, `satFlag` stays at 1 through any later operations until a clear or a reset.
- R8: `clrSat` high at a clock edge clears `satFlag`. If an accepted overflowing operation arrives on the same edge, the set wins and the flag stays at 1.
- R9: A cycle with `inValid` low or `condPass` low changes neither `result` nor `satFlag`, and gives `outValid` low on the next clock. A `clrSat` in such a cycle still acts.
- R10: `outValid` is high exactly one clock after each accepted operation, independent of the data values.
- R11: Synchronous reset sets `result` to 0, `satFlag` to 0 and `outValid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands present this cycle |
| condPass | input | 1 | Condition passed; the operation is accepted only if this and inValid are high |
| swapHalves | input | 1 | Rotate opB by 16 bits before multiplying |
| mulOnly | input | 1 | Ignore the addend and never raise the flag |
| clrSat | input | 1 | Clear the sticky saturation flag |
| opA | input | 32 | First operand, two signed halfwords |
| opB | input | 32 | Second operand, two signed halfwords |
| addend | input | 32 | Signed accumulate value |
| outValid | output | 1 | Result updated by an accepted operation |
| result | output | 32 | Low 32 bits of the exact sum |
| satFlag | output | 1 | Sticky overflow flag |

## Verification
The bench targets the most extreme operands, −32768 and 32767 in every halfword, against the two extreme addends. A design that checks overflow too narrowly misses these overflows, and one that checks too broadly flags the safe cases. Swapped-operand cases with unequal halfwords catch a design that reverses the subtraction or rotates the wrong operand. A design that lets overflow on the difference alone raise the flag shows up in the multiply-only extremes. Two further cases are a clear that coincides with an overflow, which exposes wrong clear priority, and rejected cycles with overflowing operands, which expose a design that ignores the condition-pass gate.

// File: rtl/dmsa_pkg.sv
package dmsa_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // accepted operation: capture result
    logic accum;  // addend in use, overflow check active
  } strobe_t;
endpackage

// File: rtl/dmsa_ctrl.sv
module dmsa_ctrl
  import dmsa_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  input  logic    condPass,
  input  logic    mulOnly,
  input  logic    clrSat,
  input  logic    ovf,
  output strobe_t strobe,
  output logic    satFlag,
  output logic    outValid
);
  always_comb begin
    strobe.load  = inValid && condPass;
    strobe.accum = !mulOnly;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      satFlag  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load && ovf) satFlag <= 1'b1;   // a set beats a clear on the same edge
      else if (clrSat)        satFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/dmsa_datapath.sv
module dmsa_datapath
  import dmsa_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  strobe_t               strobe,
  input  logic                  swapHalves,
  input  logic [2*HALF_W-1:0]   opA,
  input  logic [2*HALF_W-1:0]   opB,
  input  logic [2*HALF_W-1:0]   addend,
  output logic                  ovf,
  output logic [2*HALF_W-1:0]   result
);
  localparam int WORD_W  = 2 * HALF_W;
  localparam int PROD_W  = 2 * HALF_W;
  localparam int GUARD_W = 2;
  localparam int EXT_W   = WORD_W + GUARD_W;
  localparam int LANES   = 2;

  logic [WORD_W-1:0] bSel;
  assign bSel = swapHalves ? {opB[HALF_W-1:0], opB[WORD_W-1:HALF_W]} : opB;

  logic signed [EXT_W-1:0] prodExt [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [PROD_W-1:0] prod;
    assign prod       = $signed(opA[g*HALF_W +: HALF_W]) * $signed(bSel[g*HALF_W +: HALF_W]);
    assign prodExt[g] = EXT_W'(prod);
  end

  logic signed [EXT_W-1:0] diffExt, addExt, sumExt;
  always_comb begin
    diffExt = prodExt[0] - prodExt[1];
    addExt  = strobe.accum ? EXT_W'($signed(addend)) : '0;
    sumExt  = diffExt + addExt;
    ovf     = strobe.accum &&
              (sumExt[EXT_W-1:WORD_W] != {GUARD_W{sumExt[WORD_W-1]}});
  end

  always_ff @(posedge clk) begin
    if (rst)              result <= '0;
    else if (strobe.load) result <= sumExt[WORD_W-1:0];
  end
endmodule

// File: rtl/dual_mul_sub_acc.sv
module dual_mul_sub_acc
  import dmsa_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic                condPass,
  input  logic                swapHalves,
  input  logic                mulOnly,
  input  logic                clrSat,
  input  logic [2*HALF_W-1:0] opA,
  input  logic [2*HALF_W-1:0] opB,
  input  logic [2*HALF_W-1:0] addend,
  output logic                outValid,
  output logic [2*HALF_W-1:0] result,
  output logic                satFlag
);
  strobe_t strobe;
  logic    ovf;

  dmsa_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .condPass(condPass),
    .mulOnly(mulOnly), .clrSat(clrSat), .ovf(ovf),
    .strobe(strobe), .satFlag(satFlag), .outValid(outValid)
  );

  dmsa_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .swapHalves(swapHalves),
    .opA(opA), .opB(opB), .addend(addend), .ovf(ovf), .result(result)
  );
endmodule

// File: rtl/dmsa_checker.sv
module dmsa_checker #(
  parameter int HALF_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                inValid,
  input logic                condPass,
  input logic                mulOnly,
  input logic                clrSat,
  input logic                outValid,
  input logic [2*HALF_W-1:0] result,
  input logic                satFlag
);
  // R7: a set flag survives until a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(satFlag) && !$past(clrSat) && !$past(rst)) |-> satFlag);

  // R9: rejected cycle keeps the result
  a_r9_hold_result: assert property (@(posedge clk) disable iff (rst)
    (!$past(inValid && condPass) && !$past(rst)) |-> $stable(result));

  // R10: fixed one-cycle latency of the valid output
  a_r10_latency: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (outValid == $past(inValid && condPass)));

  // R6 and R9: no set from multiply-only or rejected cycles
  a_r6_no_set: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(satFlag) && ($past(mulOnly) || !$past(inValid && condPass)))
      |-> !satFlag);

  // R11: state cleared by reset
  a_r11_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!satFlag && !outValid && result == '0));
endmodule

bind dual_mul_sub_acc dmsa_checker #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .condPass(condPass),
  .mulOnly(mulOnly), .clrSat(clrSat), .outValid(outValid),
  .result(result), .satFlag(satFlag)
);

// File: tb/dual_mul_sub_acc_test.sv
module dual_mul_sub_acc_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0, condPass = 1'b0, swapHalves = 1'b0, mulOnly = 1'b0, clrSat = 1'b0;
  logic [31:0] opA = '0, opB = '0, addend = '0;
  logic        outValid, satFlag;
  logic [31:0] result;

  int total = 0;
  int bad   = 0;
  logic [31:0] expRes = '0;
  logic        expSat = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_mul_sub_acc uut (
    .clk(clk), .rst(rst), .inValid(inValid), .condPass(condPass),
    .swapHalves(swapHalves), .mulOnly(mulOnly), .clrSat(clrSat),
    .opA(opA), .opB(opB), .addend(addend),
    .outValid(outValid), .result(result), .satFlag(satFlag)
  );

  // Reference model from the requirements: {overflow, low word}
  function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] c, input logic sw, input logic mo);
    logic [31:0] bs;
    longint lo, hi, sum;
    bs  = sw ? {b[15:0], b[31:16]} : b;
    lo  = longint'($signed(a[15:0])) * longint'($signed(bs[15:0]));
    hi  = longint'($signed(a[31:16])) * longint'($signed(bs[31:16]));
    sum = lo - hi + (mo ? 64'sd0 : longint'($signed(c)));
    return {(!mo && (sum > 64'sd2147483647 || sum < -64'sd2147483648)), sum[31:0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic op(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                    input logic sw, input logic mo, input logic v, input logic cp,
                    input logic clr, input string req);
    logic [32:0] m;
    logic load;
    @(negedge clk);
    opA = a; opB = b; addend = c; swapHalves = sw; mulOnly = mo;
    inValid = v; condPass = cp; clrSat = clr;
    m = model(a, b, c, sw, mo);
    load = v && cp;
    if (load) expRes = m[31:0];
    if (load && m[32]) expSat = 1'b1;
    else if (clr)      expSat = 1'b0;
    @(negedge clk);
    inValid = 1'b0; condPass = 1'b0; clrSat = 1'b0;
    check(result == expRes, req, "result", result, expRes);
    check(satFlag == expSat, req, "satFlag", {31'd0, satFlag}, {31'd0, expSat});
    check(outValid == load, req, "outValid", {31'd0, outValid}, {31'd0, load});
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    expRes = '0; expSat = 1'b0;
    check(result == 32'd0, "R11", "result", result, 32'd0);
    check(satFlag == 1'b0, "R11", "satFlag", {31'd0, satFlag}, 32'd0);
    check(outValid == 1'b0, "R11", "outValid", {31'd0, outValid}, 32'd0);
  endtask

  task automatic t_basic();
    op(32'h0003_0002, 32'h0005_0004, 32'd10, 0, 0, 1, 1, 0, "R1");  // 2*4-3*5+10 = 3
    check(result == 32'd3, "R2", "low minus high", result, 32'd3);
    op(32'hFFFE_0007, 32'h0003_FFFB, 32'hFFFF_FF00, 0, 0, 1, 1, 0, "R1");
  endtask

  task automatic t_swap();
    op(32'h0003_0002, 32'h0005_0004, 32'd10, 1, 0, 1, 1, 0, "R3");  // 2*5-3*4+10 = 8
    check(result == 32'd8, "R3", "swapped", result, 32'd8);
  endtask

  task automatic t_mul_only();
    op(32'h0003_0002, 32'h0005_0004, 32'd1000, 0, 1, 1, 1, 0, "R4");
    check(result == 32'hFFFF_FFF9, "R4", "addend ignored", result, 32'hFFFF_FFF9);
    op(32'h8000_8000, 32'h7FFF_8000, 32'h7FFF_FFFF, 0, 1, 1, 1, 0, "R6");
    op(32'h8000_8000, 32'h8000_7FFF, 32'h8000_0000, 0, 1, 1, 1, 0, "R6");
    check(satFlag == 1'b0, "R6", "no set", {31'd0, satFlag}, 32'd0);
  endtask

  task automatic t_extremes();
    op(32'h8000_8000, 32'h7FFF_8000, 32'h8000_0000, 0, 0, 1, 1, 0, "R5");  // -32768, fits
    op(32'h8000_8000, 32'h8000_8000, 32'h7FFF_FFFF, 0, 0, 1, 1, 0, "R5");  // 0 + max, fits
    op(32'h8000_8000, 32'h7FFF_8000, 32'h7FFF_FFFF, 0, 0, 1, 1, 0, "R5");  // overflows high
    check(result == 32'hFFFF_7FFF, "R5", "wrapped", result, 32'hFFFF_7FFF);
    op(32'h0000_0001, 32'h0000_0001, 32'd5, 0, 0, 1, 1, 0, "R7");         // flag stays
    op(32'h8000_8000, 32'h7FFF_8000, 32'd0, 0, 0, 0, 1, 1, "R8");         // clear alone
    op(32'h8000_8000, 32'h8000_7FFF, 32'h8000_0000, 0, 0, 1, 1, 0, "R5"); // overflows low
    check(result == 32'h0000_8000, "R5", "wrapped low", result, 32'h0000_8000);
  endtask

  task automatic t_clear_collision();
    op(32'h8000_8000, 32'h7FFF_8000, 32'h7FFF_FFFF, 0, 0, 1, 1, 1, "R8"); // set wins
    op(32'h0000_0000, 32'h0000_0000, 32'd0, 0, 0, 1, 1, 1, "R8");         // clear with load
  endtask

  task automatic t_rejected();
    op(32'h0000_0002, 32'h0000_0003, 32'd1, 0, 0, 1, 1, 0, "R9");
    op(32'h8000_8000, 32'h7FFF_8000, 32'h7FFF_FFFF, 0, 0, 1, 0, 0, "R9"); // cond fails
    op(32'h8000_8000, 32'h7FFF_8000, 32'h7FFF_FFFF, 1, 0, 0, 1, 0, "R9"); // not valid
    check(result == 32'd7, "R9", "held", result, 32'd7);
  endtask

  task automatic t_random();
    for (int i = 0; i < 60; i++)
      op($urandom, $urandom, $urandom, 1'($urandom), 1'($urandom), 1'b1,
         1'($urandom % 4 != 0), 1'($urandom % 5 == 0), "R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_swap();
    t_mul_only();
    t_extremes();
    t_clear_collision();
    t_rejected();
    t_random();
    op(32'h8000_8000, 32'h7FFF_8000, 32'h7FFF_FFFF, 0, 0, 1, 1, 0, "R5");
    t_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule